// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Matcher

This block sits beside the timekeeping core of a real-time clock. It holds three alarm registers, one each for minutes, hours and day of week. It compares them with the running counters when the core pulses its once-per-minute tick. Each alarm register holds a mask bit and a BCD value. A set mask bit removes that field from the comparison. The mask bits can only combine in a few meaningful ways, which give an alarm every minute, on a minute match, on an hour-and-minute match, or on a full day, hour and minute match.

A qualifying tick produces a one-cycle event strobe and sets a sticky flag. The flag stays set until software reads or writes any of the three alarm registers. Mask patterns outside the four meaningful ones are resolved to a fixed fallback, so behaviour is always defined.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset, all three alarm registers read 0, and `alarm_evt` and `alarm_flag` are 0.
- R2: A write with `reg_sel` 0 (minutes), 1 (hours) or 2 (day) stores `reg_wdata` in that register, and `reg_rdata` returns it. Bit 7 is the mask bit and bits 6:0 are the compared value. With `reg_sel` = 3, writes are ignored and `reg_rdata` reads 0.
- R3: When the minutes, hours and day mask bits are all 1, every tick produces an event.
- R4: When the minutes mask is 0 and the hours and day masks are 1, a tick produces an event only if `cur_min` equals the minutes value.
- R5: When the minutes and hours masks are 0 and the day mask is 1, a tick produces an event only if both minutes and hours match.
- R6: When all three mask bits are 0, a tick produces an event only if minutes, hours and day all match.
- R7: Other mask patterns are resolved as follows. If the minutes mask is 1, the block acts as in R3. If the minutes mask is 0 and the hours mask is 1, it acts as in R4.
- R8: `alarm_evt` is high for exactly the one cycle after a qualifying tick cycle. Without a tick it never goes high, whatever the counters hold.
- R9: `alarm_flag` rises together with `alarm_evt` and stays high after the strobe ends.
- R10: A read or write with `reg_sel` 0 to 2 clears `alarm_flag` at the next edge. Access with `reg_sel` = 3 does not clear it. If a new event is raised at the same edge as the clear, the flag stays set.
- R11: A register write in a tick cycle does not affect that tick's comparison, which uses the old contents. The new value is used from the next tick on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Alarm register write strobe |
| reg_rd | input | 1 | Alarm register read strobe (clears flag) |
| reg_sel | input | 2 | Register select: 0 minutes, 1 hours, 2 day |
| reg_wdata | input | 8 | Write data: bit 7 mask, bits 6:0 value |
| reg_rdata | output | 8 | Read data of the selected register |
| min_tick | input | 1 | One-cycle pulse marking a new minute |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hr | input | 7 | Current hours, BCD |
| cur_day | input | 7 | Current day of week, BCD |
| alarm_evt | output | 1 | One-cycle alarm event |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The hardest case to reach is a register access that lands on the same edge where a tick raises a new event. Both the clear-versus-set priority and the rule that the tick uses the old register value depend on this collision. The bench drives the write or read in the same cycle as the tick, and then checks that the event appears, that the flag stays set, and that the following ticks use the new value. Around this case, the bench sweeps all eight mask patterns against every combination of matching and non-matching fields.

// File: rtl/tod_alarm_pkg.sv
// Shared constants and types for the time-of-day alarm matcher.
package tod_alarm_pkg;
    localparam int NUM_FIELDS = 3;
    localparam int SEL_W      = 2;

    // Field index within the alarm register set.
    typedef enum logic [SEL_W-1:0] {
        FLD_MIN = 2'd0,
        FLD_HR  = 2'd1,
        FLD_DAY = 2'd2
    } field_e;

    // Resolved comparison mode.
    typedef enum logic [1:0] {
        MODE_EVERY = 2'd0,
        MODE_MIN   = 2'd1,
        MODE_HM    = 2'd2,
        MODE_FULL  = 2'd3
    } match_mode_e;
endpackage

// File: rtl/tod_alarm_regs.sv
// Alarm register file: one register per field, each {mask, value}.
// Assumes: selects beyond the field count are ignored on write and read 0.
module tod_alarm_regs
    import tod_alarm_pkg::*;
#(
    parameter int VAL_W = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            sel,
    input  logic [VAL_W:0]              wdata,
    output logic [VAL_W:0]              rdata,
    output logic [NUM_FIELDS-1:0]       mask,
    output logic [NUM_FIELDS*VAL_W-1:0] values
);
    localparam int REG_W = VAL_W + 1;

    logic [REG_W-1:0] regs [NUM_FIELDS];

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        // Store the field register on a write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wr_en && (sel == SEL_W'(i))) begin
                regs[i] <= wdata;
            end
        end
        assign mask[i]                    = regs[i][REG_W-1];
        assign values[i*VAL_W +: VAL_W]   = regs[i][VAL_W-1:0];
    end

    // Return the selected register; out-of-range selects read zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (sel == SEL_W'(i)) begin
                rdata = regs[i];
            end
        end
    end
endmodule

// File: rtl/tod_alarm_mode_dec.sv
// Mask decoder: maps the three mask bits to a comparison mode.
// Assumes mask bit order {day, hour, minute}; patterns that are not
// meaningful fall back on the first masked field, counted from minutes.
module tod_alarm_mode_dec
    import tod_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0] mask,
    output match_mode_e           mode
);
    // Priority from the finest field upward.
    always_comb begin
        if (mask[FLD_MIN]) begin
            mode = MODE_EVERY;
        end else if (mask[FLD_HR]) begin
            mode = MODE_MIN;
        end else if (mask[FLD_DAY]) begin
            mode = MODE_HM;
        end else begin
            mode = MODE_FULL;
        end
    end
endmodule

// File: rtl/tod_alarm_cmp.sv
// Field comparator: per-field equality, combined according to mode.
// Assumes values are compared as raw BCD, with no range check.
module tod_alarm_cmp
    import tod_alarm_pkg::*;
#(
    parameter int VAL_W = 7
) (
    input  logic [NUM_FIELDS*VAL_W-1:0] alarm_vals,
    input  logic [NUM_FIELDS*VAL_W-1:0] cur_vals,
    input  match_mode_e                 mode,
    output logic                        match
);
    logic [NUM_FIELDS-1:0] eq;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_eq
        assign eq[i] = (alarm_vals[i*VAL_W +: VAL_W] == cur_vals[i*VAL_W +: VAL_W]);
    end

    // Combine the field matches required by the mode.
    always_comb begin
        unique case (mode)
            MODE_EVERY: match = 1'b1;
            MODE_MIN:   match = eq[FLD_MIN];
            MODE_HM:    match = eq[FLD_MIN] & eq[FLD_HR];
            default:    match = &eq;
        endcase
    end
endmodule

// File: rtl/tod_alarm_flag.sv
// Event and flag unit: strobe on a qualifying tick, sticky flag cleared
// by register access. Assumes the tick is a single-cycle pulse.
module tod_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic access,
    output logic evt,
    output logic flag
);
    logic fire;
    assign fire = tick & match;

    // Register the one-cycle event strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= fire;
    end

    // Sticky flag: a new event outranks a clear at the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (fire)   flag <= 1'b1;
        else if (access) flag <= 1'b0;
    end
endmodule

// File: rtl/tod_alarm_match.sv
// Top of the time-of-day alarm matcher. Holds the alarm registers and
// compares them with the timekeeping counters on each minute tick.
// Assumes counters are stable during the tick cycle.
module tod_alarm_match
    import tod_alarm_pkg::*;
#(
    parameter int VAL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_sel,
    input  logic [VAL_W:0]   reg_wdata,
    output logic [VAL_W:0]   reg_rdata,
    input  logic             min_tick,
    input  logic [VAL_W-1:0] cur_min,
    input  logic [VAL_W-1:0] cur_hr,
    input  logic [VAL_W-1:0] cur_day,
    output logic             alarm_evt,
    output logic             alarm_flag
);
    logic [NUM_FIELDS-1:0]       mask;
    logic [NUM_FIELDS*VAL_W-1:0] alarm_vals;
    logic [NUM_FIELDS*VAL_W-1:0] cur_vals;
    match_mode_e                 mode;
    logic                        match;
    logic                        access;

    assign cur_vals = {cur_day, cur_hr, cur_min};
    assign access   = (reg_wr | reg_rd) & (reg_sel < SEL_W'(NUM_FIELDS));

    tod_alarm_regs #(.VAL_W(VAL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .mask(mask), .values(alarm_vals)
    );

    tod_alarm_mode_dec dec_i (.mask(mask), .mode(mode));

    tod_alarm_cmp #(.VAL_W(VAL_W)) cmp_i (
        .alarm_vals(alarm_vals), .cur_vals(cur_vals), .mode(mode), .match(match)
    );

    tod_alarm_flag flag_i (
        .clk(clk), .rst_n(rst_n), .tick(min_tick), .match(match),
        .access(access), .evt(alarm_evt), .flag(alarm_flag)
    );
endmodule

// File: rtl/tod_alarm_match_chk.sv
// Assertion checker for tod_alarm_match, attached by bind.
module tod_alarm_match_chk
    import tod_alarm_pkg::*;
#(
    parameter int VAL_W = 7
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_wr,
    input logic                        reg_rd,
    input logic [1:0]                  reg_sel,
    input logic                        min_tick,
    input logic [VAL_W-1:0]            cur_min,
    input logic [VAL_W-1:0]            cur_hr,
    input logic [VAL_W-1:0]            cur_day,
    input logic                        alarm_evt,
    input logic                        alarm_flag,
    input logic [NUM_FIELDS-1:0]       mask,
    input logic [NUM_FIELDS*VAL_W-1:0] alarm_vals,
    input match_mode_e                 mode
);
    logic acc;
    assign acc = (reg_wr | reg_rd) && (reg_sel != 2'd3);

    p_evt_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> $past(min_tick));
    p_evt_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> alarm_flag);
    p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> alarm_evt);
    p_flag_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flag) |-> $past(acc));
    p_every_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (min_tick && mode == MODE_EVERY) |=> alarm_evt);
    p_min_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt && $past(mode) == MODE_MIN) |->
        ($past(cur_min) == $past(alarm_vals[VAL_W-1:0])));
    p_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt && $past(mode) == MODE_FULL) |->
        ($past(cur_vals_w()) == $past(alarm_vals)));
    p_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask[0] |-> (mode == MODE_EVERY));

    function automatic logic [NUM_FIELDS*VAL_W-1:0] cur_vals_w();
        return {cur_day, cur_hr, cur_min};
    endfunction
endmodule

bind tod_alarm_match tod_alarm_match_chk #(.VAL_W(VAL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .min_tick(min_tick), .cur_min(cur_min),
    .cur_hr(cur_hr), .cur_day(cur_day), .alarm_evt(alarm_evt),
    .alarm_flag(alarm_flag), .mask(mask), .alarm_vals(alarm_vals), .mode(mode)
);

// File: tb/tod_alarm_match_tb_top.sv
// Self-checking bench: sweeps every mask pattern against every
// match/mismatch combination of the three fields.
module tod_alarm_match_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       min_tick = 1'b0;
    logic [6:0] cur_min = '0, cur_hr = '0, cur_day = '0;
    logic       alarm_evt, alarm_flag;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tod_alarm_match dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .min_tick(min_tick), .cur_min(cur_min), .cur_hr(cur_hr),
        .cur_day(cur_day), .alarm_evt(alarm_evt), .alarm_flag(alarm_flag)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_sel = s; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    // Pulse one tick; evt is checked in the following cycle, and again one cycle later.
    task automatic tick_check(input string req, input logic exp);
        @(negedge clk); min_tick = 1'b1;
        @(negedge clk); min_tick = 1'b0;
        check(req, {7'd0, alarm_evt}, {7'd0, exp});
        check("R9", {7'd0, alarm_flag}, {7'd0, exp});
        @(negedge clk);
        check("R8", {7'd0, alarm_evt}, 8'd0);
    endtask

    initial begin
        #400000;
        fails++; tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {6'd0, alarm_evt, alarm_flag}, 8'd0);
        for (int s = 0; s < 3; s++) begin
            rd_reg(2'(s), d); check("R1", d, 8'h00);
        end
        // R2: write and readback; select 3 ignored
        wr_reg(2'd0, 8'hA5); wr_reg(2'd1, 8'h12); wr_reg(2'd2, 8'h87);
        wr_reg(2'd3, 8'hFF);
        rd_reg(2'd0, d); check("R2", d, 8'hA5);
        rd_reg(2'd1, d); check("R2", d, 8'h12);
        rd_reg(2'd2, d); check("R2", d, 8'h87);
        rd_reg(2'd3, d); check("R2", d, 8'h00);

        // R8: no tick, no event, even in every-minute mode
        wr_reg(2'd0, 8'h80); wr_reg(2'd1, 8'h80); wr_reg(2'd2, 8'h80);
        repeat (5) begin
            @(negedge clk); check("R8", {7'd0, alarm_evt}, 8'd0);
        end

        // Sweep: all mask patterns x field match patterns
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 8; p++) begin
                logic mm, mh, md, exp;
                string req;
                mm = m[0]; mh = m[1]; md = m[2];
                wr_reg(2'd0, {mm, 7'h30});
                wr_reg(2'd1, {mh, 7'h12});
                wr_reg(2'd2, {md, 7'h03});
                rd_reg(2'd0, d); // clears flag (R10)
                check("R10", {7'd0, alarm_flag}, 8'd0);
                cur_min = p[0] ? 7'h30 : 7'h31;
                cur_hr  = p[1] ? 7'h12 : 7'h09;
                cur_day = p[2] ? 7'h03 : 7'h05;
                if (mm) begin
                    exp = 1'b1; req = (m == 7) ? "R3" : "R7";
                end else if (mh) begin
                    exp = p[0]; req = (m == 6) ? "R4" : "R7";
                end else if (md) begin
                    exp = p[0] & p[1]; req = "R5";
                end else begin
                    exp = p[0] & p[1] & p[2]; req = "R6";
                end
                if (req == "R7" && p == 0)
                    $display("[TB] note: mask pattern %0d is not a meaningful combination", m);
                tick_check(req, exp);
            end
        end

        // R10: flag sticky; select 3 access does not clear; select 1 read does
        wr_reg(2'd0, 8'h80);
        tick_check("R3", 1'b1);
        repeat (3) @(negedge clk);
        check("R9", {7'd0, alarm_flag}, 8'd1);
        rd_reg(2'd3, d); check("R10", {7'd0, alarm_flag}, 8'd1);
        wr_reg(2'd3, 8'h00); check("R10", {7'd0, alarm_flag}, 8'd1);
        rd_reg(2'd1, d); check("R10", {7'd0, alarm_flag}, 8'd0);

        // R11 / R10: write during tick uses old value; event wins over clear
        wr_reg(2'd0, 8'h15); wr_reg(2'd1, 8'h08); wr_reg(2'd2, 8'h02);
        cur_min = 7'h15; cur_hr = 7'h08; cur_day = 7'h02;
        @(negedge clk); min_tick = 1'b1; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h20;
        @(negedge clk); min_tick = 1'b0; reg_wr = 1'b0;
        check("R11", {7'd0, alarm_evt}, 8'd1);
        check("R10", {7'd0, alarm_flag}, 8'd1);
        rd_reg(2'd0, d); check("R11", d, 8'h20);
        tick_check("R11", 1'b0);
        cur_min = 7'h20;
        tick_check("R11", 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule